// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block walks an SDRAM device through its power-up bring-up after reset, with no software involved. After reset is released it raises the clock-enable line. It then issues an ordered script of commands on phase 0 of the PHY command interface: precharge-all, mode-register loads, extended-mode-register loads and auto refreshes. Each command carries its own address and bank value.

The memory family is chosen at elaboration time through a parameter: single data rate, double data rate, low-power double data rate, or second-generation double data rate. Other parameters give the CAS latency and the number of PHY phases per controller clock. These decide the length of the script, the bank address used for each extended register, and the exact bits of the mode-register value. Waits between steps are counted in controller clock cycles. During every wait the command lines carry a NOP.

When the final wait has run out, a done flag rises and stays high. The memory controller can then take over the command bus.

Top module: `sdinit_seq`

## Requirements
- R1: While `rst` is high, `cke` is low, `cs_n`, `ras_n`, `cas_n` and `we_n` are all high (NOP), `addr`, `bank` and `done` are zero, and the script returns to its first step, so a reset asserted mid-script restarts the whole sequence.
- R2: `cke` rises in the first cycle after reset is released and stays high. No command (`cs_n` low) is issued while `cke` is low. The first command follows 2000 NOP cycles later (`CKE_WAIT`).
- R3: Every command lasts exactly one cycle. Pin encodings {`ras_n`,`cas_n`,`we_n`} with `cs_n`=0 are: precharge-all 3'b010, with `addr` 0x400 (A10 set) and `bank` 0; register load 3'b000; auto refresh 3'b001. The NOP has all four lines high.
- R4: A precharge-all and every extended-register load are followed at once by the next command. An auto refresh is followed by 4 NOP cycles (`REF_WAIT`). Both ordinary mode-register loads are followed by 200 NOP cycles (`MODE_WAIT`).
- R5: The mode value is log2(BL) + (CL << 4), on bank 0. BL equals the phase count for single data rate and twice the phase count for the double-rate families. The second-generation family also adds 2 << 9.
- R6: After the extended loads (or right after the first precharge-all for single data rate) come, in this order: a mode load with bit 8 (DLL reset) added, a precharge-all, two auto refreshes, and a mode load without bit 8.
- R7: The single-data-rate script has no extended load. The double-data-rate script loads value 0 on bank 1 right after the first precharge-all. The low-power script does the same on bank 2.
- R8: The second-generation script loads value 0 on bank 3, then bank 2, then bank 1, right after the first precharge-all and before the DLL-reset mode load.
- R9: The second-generation script ends with two loads on bank 1 after the final mode load: first 0x380 (driver-calibration default), then 0 (calibration exit).
- R10: `done` rises in the cycle after the last wait expires, that is, the slot the next command would have used. It then stays high with NOP on the command lines until reset.
- R11: In every NOP cycle `addr` and `bank` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address for the phase-0 command |
| bank | output | BANK_W | Bank address for the phase-0 command |
| done | output | 1 | Script finished; held until reset |

## Verification
Cycle 1 is the first clock edge with reset low, and that is when `cke` is due. Every later command is due one cycle after the previous command plus that command's wait, and `done` is due at the slot after the last wait. The scoreboard driver computes each due cycle from the requirements and queues it together with the pins, address and bank. The monitor samples on the falling clock edge, counts edges since reset, and pops an item only when `cs_n` is low. It then compares the due cycle as well as the fields, so a command that is early, late, extra or missing is caught. Checks on `done` fall on the cycle before its due slot and on the slot itself. A mid-script reset is also exercised, to confirm that the script starts over.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [1:0] {
        MEM_SDR   = 2'd0,
        MEM_DDR   = 2'd1,
        MEM_LPDDR = 2'd2,
        MEM_DDR2  = 2'd3
    } mem_kind_e;

    typedef enum logic [3:0] {
        OP_CKE_UP,
        OP_PRE_ALL,
        OP_XREG3,
        OP_XREG2,
        OP_XREG1,
        OP_MODE_DLL,
        OP_REFRESH,
        OP_MODE_RUN,
        OP_CAL_DEF,
        OP_CAL_EXIT
    } init_op_e;

    typedef enum logic [1:0] {
        GAP_NONE,
        GAP_CKE,
        GAP_MODE,
        GAP_REF
    } gap_e;

    typedef enum logic [1:0] {
        PH_ISSUE,
        PH_GAP,
        PH_DONE
    } seq_phase_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_NOP  = 4'b1111;
    localparam cmd_pins_t PINS_PRE  = 4'b0010;
    localparam cmd_pins_t PINS_LOAD = 4'b0000;
    localparam cmd_pins_t PINS_REF  = 4'b0001;

    function automatic int unsigned script_len(mem_kind_e k);
        case (k)
            MEM_SDR:  return 7;
            MEM_DDR2: return 12;
            default:  return 8;
        endcase
    endfunction

    function automatic init_op_e script_op(mem_kind_e k, int unsigned idx);
        init_op_e op;
        case (k)
            MEM_DDR2: begin
                case (idx)
                    0:       op = OP_CKE_UP;
                    1:       op = OP_PRE_ALL;
                    2:       op = OP_XREG3;
                    3:       op = OP_XREG2;
                    4:       op = OP_XREG1;
                    5:       op = OP_MODE_DLL;
                    6:       op = OP_PRE_ALL;
                    7:       op = OP_REFRESH;
                    8:       op = OP_REFRESH;
                    9:       op = OP_MODE_RUN;
                    10:      op = OP_CAL_DEF;
                    default: op = OP_CAL_EXIT;
                endcase
            end
            MEM_SDR: begin
                case (idx)
                    0:       op = OP_CKE_UP;
                    1:       op = OP_PRE_ALL;
                    2:       op = OP_MODE_DLL;
                    3:       op = OP_PRE_ALL;
                    4:       op = OP_REFRESH;
                    5:       op = OP_REFRESH;
                    default: op = OP_MODE_RUN;
                endcase
            end
            default: begin
                case (idx)
                    0:       op = OP_CKE_UP;
                    1:       op = OP_PRE_ALL;
                    2:       op = OP_XREG1;
                    3:       op = OP_MODE_DLL;
                    4:       op = OP_PRE_ALL;
                    5:       op = OP_REFRESH;
                    6:       op = OP_REFRESH;
                    default: op = OP_MODE_RUN;
                endcase
            end
        endcase
        return op;
    endfunction

    function automatic gap_e op_gap(init_op_e op);
        case (op)
            OP_CKE_UP:               return GAP_CKE;
            OP_MODE_DLL, OP_MODE_RUN: return GAP_MODE;
            OP_REFRESH:              return GAP_REF;
            default:                 return GAP_NONE;
        endcase
    endfunction

    function automatic cmd_pins_t op_pins(init_op_e op);
        case (op)
            OP_CKE_UP:  return PINS_NOP;
            OP_PRE_ALL: return PINS_PRE;
            OP_REFRESH: return PINS_REF;
            default:    return PINS_LOAD;
        endcase
    endfunction

    function automatic int unsigned burst_log2(mem_kind_e k, int unsigned phases);
        int unsigned bl;
        bl = (k == MEM_SDR) ? phases : 2 * phases;
        return $clog2(bl);
    endfunction

endpackage

// File: rtl/sdinit_step_rom.sv
module sdinit_step_rom
    import sdinit_pkg::*;
#(
    parameter mem_kind_e MEM_KIND = MEM_DDR2,
    parameter int CAS_LAT  = 3,
    parameter int PHASES   = 2,
    parameter int ADDR_W   = 13,
    parameter int BANK_W   = 2,
    localparam int LEN     = script_len(MEM_KIND),
    localparam int IDX_W   = $clog2(LEN)
) (
    input  logic [IDX_W-1:0]  idx,
    output init_op_e          op,
    output cmd_pins_t         pins,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output gap_e              gap,
    output logic              last
);
    localparam int WR_FIELD  = (MEM_KIND == MEM_DDR2) ? (2 << 9) : 0;
    localparam int MODE_BASE = int'(burst_log2(MEM_KIND, PHASES)) + (CAS_LAT << 4) + WR_FIELD;
    localparam int DLL_BIT   = 1 << 8;
    localparam int CAL_DEF   = 7 << 7;
    localparam int A10       = 1 << 10;
    localparam int XREG1_BA  = (MEM_KIND == MEM_LPDDR) ? 2 : 1;

    always_comb begin
        op   = script_op(MEM_KIND, int'(idx));
        pins = op_pins(op);
        gap  = op_gap(op);
        last = (idx == IDX_W'(LEN - 1));
        addr = '0;
        bank = '0;
        case (op)
            OP_PRE_ALL:  addr = ADDR_W'(A10);
            OP_XREG3:    bank = BANK_W'(3);
            OP_XREG2:    bank = BANK_W'(2);
            OP_XREG1:    bank = BANK_W'(XREG1_BA);
            OP_MODE_DLL: addr = ADDR_W'(MODE_BASE + DLL_BIT);
            OP_MODE_RUN: addr = ADDR_W'(MODE_BASE);
            OP_CAL_DEF: begin
                addr = ADDR_W'(CAL_DEF);
                bank = BANK_W'(1);
            end
            OP_CAL_EXIT: bank = BANK_W'(1);
            default: ;
        endcase
    end
endmodule

// File: rtl/sdinit_gap_timer.sv
module sdinit_gap_timer
    import sdinit_pkg::*;
#(
    parameter int CKE_WAIT  = 2000,
    parameter int MODE_WAIT = 200,
    parameter int REF_WAIT  = 4,
    localparam int MAX_A    = (CKE_WAIT > MODE_WAIT) ? CKE_WAIT : MODE_WAIT,
    localparam int MAX_WAIT = (MAX_A > REF_WAIT) ? MAX_A : REF_WAIT,
    localparam int CNT_W    = $clog2(MAX_WAIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  gap_e gap,
    output logic gap_zero,
    output logic final_tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] span;

    always_comb begin
        case (gap)
            GAP_CKE:  span = CNT_W'(CKE_WAIT);
            GAP_MODE: span = CNT_W'(MODE_WAIT);
            GAP_REF:  span = CNT_W'(REF_WAIT);
            default:  span = '0;
        endcase
    end

    assign gap_zero   = (span == '0);
    assign final_tick = (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= span;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end
endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
    import sdinit_pkg::*;
#(
    parameter mem_kind_e MEM_KIND = MEM_DDR2,
    parameter int CAS_LAT   = 3,
    parameter int PHASES    = 2,
    parameter int ADDR_W    = 13,
    parameter int BANK_W    = 2,
    parameter int CKE_WAIT  = 2000,
    parameter int MODE_WAIT = 200,
    parameter int REF_WAIT  = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic              done
);
    localparam int LEN   = script_len(MEM_KIND);
    localparam int IDX_W = $clog2(LEN);

    seq_phase_e        phase;
    logic [IDX_W-1:0]  idx;
    init_op_e          step_op;
    cmd_pins_t         step_pins;
    logic [ADDR_W-1:0] step_addr;
    logic [BANK_W-1:0] step_bank;
    gap_e              step_gap;
    logic              step_last;
    logic              gap_zero;
    logic              final_tick;
    cmd_pins_t         pins_q;

    sdinit_step_rom #(
        .MEM_KIND(MEM_KIND), .CAS_LAT(CAS_LAT), .PHASES(PHASES),
        .ADDR_W(ADDR_W), .BANK_W(BANK_W)
    ) u_rom (
        .idx(idx), .op(step_op), .pins(step_pins), .addr(step_addr),
        .bank(step_bank), .gap(step_gap), .last(step_last)
    );

    sdinit_gap_timer #(
        .CKE_WAIT(CKE_WAIT), .MODE_WAIT(MODE_WAIT), .REF_WAIT(REF_WAIT)
    ) u_timer (
        .clk(clk), .rst(rst), .load(phase == PH_ISSUE), .gap(step_gap),
        .gap_zero(gap_zero), .final_tick(final_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_ISSUE;
            idx    <= '0;
            cke    <= 1'b0;
            pins_q <= PINS_NOP;
            addr   <= '0;
            bank   <= '0;
            done   <= 1'b0;
        end else begin
            case (phase)
                PH_ISSUE: begin
                    pins_q <= step_pins;
                    addr   <= step_addr;
                    bank   <= step_bank;
                    if (step_op == OP_CKE_UP)
                        cke <= 1'b1;
                    if (!gap_zero)
                        phase <= PH_GAP;
                    else if (step_last)
                        phase <= PH_DONE;
                    else
                        idx <= idx + IDX_W'(1);
                end
                PH_GAP: begin
                    pins_q <= PINS_NOP;
                    addr   <= '0;
                    bank   <= '0;
                    if (final_tick) begin
                        if (step_last) begin
                            phase <= PH_DONE;
                        end else begin
                            phase <= PH_ISSUE;
                            idx   <= idx + IDX_W'(1);
                        end
                    end
                end
                default: begin
                    pins_q <= PINS_NOP;
                    addr   <= '0;
                    bank   <= '0;
                    done   <= 1'b1;
                end
            endcase
        end
    end

    assign cs_n  = pins_q.cs_n;
    assign ras_n = pins_q.ras_n;
    assign cas_n = pins_q.cas_n;
    assign we_n  = pins_q.we_n;
endmodule

// File: rtl/sdinit_checker.sv
module sdinit_checker #(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BANK_W-1:0] bank,
    input logic              done
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!cke && cs_n && ras_n && cas_n && we_n && !done));

    assert_cke_hold_R2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> !$fell(cke));

    assert_cmd_needs_cke_R2: assert property (@(posedge clk) disable iff (rst)
        !cke |-> cs_n);

    assert_cmd_row_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> !ras_n);

    assert_refresh_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !cas_n && we_n) |=> cs_n);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && ras_n && cas_n && we_n));

    assert_nop_fields_R11: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (addr == '0 && bank == '0));
endmodule

bind sdinit_seq sdinit_checker #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/sim_sdinit_seq.sv
module sim_sdinit_seq;
    import sdinit_pkg::*;

    typedef struct {
        int        cyc;
        logic [3:0] pins;
        int        addr;
        int        bank;
        string     tag;
    } exp_t;

    localparam logic [3:0] P_PRE  = 4'b0010;
    localparam logic [3:0] P_LOAD = 4'b0000;
    localparam logic [3:0] P_REF  = 4'b0001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [3:0]  cke_v, done_v;
    logic [3:0]  pins_v [4];
    logic [12:0] addr_v [4];
    logic [1:0]  bank_v [4];

    sdinit_seq #(.MEM_KIND(MEM_DDR2), .CAS_LAT(3), .PHASES(2)) u0 (
        .clk(clk), .rst(rst), .cke(cke_v[0]), .cs_n(pins_v[0][3]), .ras_n(pins_v[0][2]),
        .cas_n(pins_v[0][1]), .we_n(pins_v[0][0]), .addr(addr_v[0]), .bank(bank_v[0]), .done(done_v[0]));
    sdinit_seq #(.MEM_KIND(MEM_SDR), .CAS_LAT(2), .PHASES(2)) u1 (
        .clk(clk), .rst(rst), .cke(cke_v[1]), .cs_n(pins_v[1][3]), .ras_n(pins_v[1][2]),
        .cas_n(pins_v[1][1]), .we_n(pins_v[1][0]), .addr(addr_v[1]), .bank(bank_v[1]), .done(done_v[1]));
    sdinit_seq #(.MEM_KIND(MEM_DDR), .CAS_LAT(3), .PHASES(1)) u2 (
        .clk(clk), .rst(rst), .cke(cke_v[2]), .cs_n(pins_v[2][3]), .ras_n(pins_v[2][2]),
        .cas_n(pins_v[2][1]), .we_n(pins_v[2][0]), .addr(addr_v[2]), .bank(bank_v[2]), .done(done_v[2]));
    sdinit_seq #(.MEM_KIND(MEM_LPDDR), .CAS_LAT(3), .PHASES(4)) u3 (
        .clk(clk), .rst(rst), .cke(cke_v[3]), .cs_n(pins_v[3][3]), .ras_n(pins_v[3][2]),
        .cas_n(pins_v[3][1]), .we_n(pins_v[3][0]), .addr(addr_v[3]), .bank(bank_v[3]), .done(done_v[3]));

    exp_t q [4][$];
    int   tnow [4];
    int   done_at [4] = '{-1000, -1000, -1000, -1000};
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    logic rst_q = 1'b1;
    bit   finished = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic add(int k, logic [3:0] p, int a, int b, int w, string tag);
        exp_t e;
        e.cyc = tnow[k]; e.pins = p; e.addr = a; e.bank = b; e.tag = tag;
        q[k].push_back(e);
        tnow[k] = tnow[k] + w + 1;
    endtask

    // driver: expected script per family (0 sdr, 1 ddr, 2 lpddr, 3 ddr2)
    task automatic build(int k, int kind, int cl, int ph);
        int bl;
        int mr;
        bl = (kind == 0) ? ph : 2 * ph;
        mr = $clog2(bl) + (cl << 4) + ((kind == 3) ? (2 << 9) : 0);
        tnow[k] = 1 + 2000 + 1;                          // R2
        add(k, P_PRE, 'h400, 0, 0, "R3");
        if (kind == 3) begin
            add(k, P_LOAD, 0, 3, 0, "R8");
            add(k, P_LOAD, 0, 2, 0, "R8");
            add(k, P_LOAD, 0, 1, 0, "R8");
        end else if (kind == 1) begin
            add(k, P_LOAD, 0, 1, 0, "R7");
        end else if (kind == 2) begin
            add(k, P_LOAD, 0, 2, 0, "R7");
        end
        add(k, P_LOAD, mr + 'h100, 0, 200, "R6");
        add(k, P_PRE, 'h400, 0, 0, "R6");
        add(k, P_REF, 0, 0, 4, "R4");
        add(k, P_REF, 0, 0, 4, "R4");
        add(k, P_LOAD, mr, 0, 200, "R5");
        if (kind == 3) begin
            add(k, P_LOAD, 'h380, 1, 0, "R9");
            add(k, P_LOAD, 0, 1, 0, "R9");
        end
        done_at[k] = tnow[k];
    endtask

    always @(posedge clk) rst_q <= rst;

    // monitor
    always @(negedge clk) begin
        if (rst_q) cyc = 0;
        else       cyc = cyc + 1;
        if (!rst_q) begin
            for (int i = 0; i < 4; i++) begin
                if (!pins_v[i][3]) begin
                    if (q[i].size() == 0) begin
                        chk(1'b0, "R3", "unexpected command cycle", cyc, 0);
                    end else begin
                        exp_t e;
                        e = q[i].pop_front();
                        chk(cyc == e.cyc, e.tag, "command cycle", cyc, e.cyc);
                        chk(pins_v[i] == e.pins, e.tag, "command pins", int'(pins_v[i]), int'(e.pins));
                        chk(int'(addr_v[i]) == e.addr, e.tag, "address", int'(addr_v[i]), e.addr);
                        chk(int'(bank_v[i]) == e.bank, e.tag, "bank", int'(bank_v[i]), e.bank);
                    end
                end
                if (cyc == 1)
                    chk(cke_v[i] == 1'b1, "R2", "cke after release", int'(cke_v[i]), 1);
                if (cyc == 1000) begin
                    chk(pins_v[i] == 4'hF, "R2", "nop during cke wait", int'(pins_v[i]), 'hF);
                    chk(addr_v[i] == '0 && bank_v[i] == '0, "R11", "nop address", int'(addr_v[i]), 0);
                end
                if (cyc == done_at[i] - 1)
                    chk(done_v[i] == 1'b0, "R10", "done before slot", int'(done_v[i]), 0);
                if (cyc == done_at[i]) begin
                    chk(done_v[i] == 1'b1, "R10", "done at slot", int'(done_v[i]), 1);
                    chk(q[i].size() == 0, "R6", "commands left", q[i].size(), 0);
                end
                if (cyc == done_at[i] + 50) begin
                    chk(done_v[i] == 1'b1 && pins_v[i] == 4'hF, "R10", "done held with nop",
                        int'({done_v[i], pins_v[i]}), 'h1F);
                    chk(cke_v[i] == 1'b1, "R2", "cke held", int'(cke_v[i]), 1);
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic reset_checks();
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk(cke_v[i] == 1'b0, "R1", "cke in reset", int'(cke_v[i]), 0);
            chk(pins_v[i] == 4'hF && addr_v[i] == '0 && bank_v[i] == '0 && done_v[i] == 1'b0,
                "R1", "quiet in reset", int'({done_v[i], pins_v[i]}), 'hF);
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (5) @(posedge clk);
        reset_checks();
        @(posedge clk); #1 rst = 1'b0;
        repeat (1500) @(posedge clk);
        #1 rst = 1'b1;                       // R1: reset mid-script
        repeat (3) @(posedge clk);
        reset_checks();
        build(0, 3, 3, 2);
        build(1, 0, 2, 2);
        build(2, 1, 3, 1);
        build(3, 2, 3, 4);
        @(posedge clk); #1 rst = 1'b0;
        repeat (2600) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 4; i++)
            chk(q[i].size() == 0, "R3", "final queue empty", q[i].size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R10 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule